// File: doc/BRIEF.md
# Dual-Mode Code/Data Memory Strobe Router

This block sits between a small microcontroller core's 16-bit external bus and the on-chip memories. For every cycle it looks at the bus address and at the three active-low strobes: program fetch, data read and data write. It then decides whether the access is served by the 8 KB main RAM at the bottom of the map, by the 512-byte scratch RAM, by the register and endpoint-buffer window, or by whatever is attached to the external pins. Accesses served on chip raise one internal chip select and drive a shared internal address and strobe pair. The matching external strobe is held high. Because of this, a full 64 KB external memory can be wired to the pins with no address decoding of its own.

A mode input selects where code lives. In internal-code mode, fetches in the low 8 KB are merged with data reads onto the main RAM, so that region acts as both code and data. In external-code mode, every fetch goes to the pins and the main RAM serves data only. Fetches above the low 8 KB always go out, because the upper on-chip regions never hold code. A bulk-transfer agent (download, upload, boot loader) may ask for the internal port at the same time. It wins over the core and stalls it for one cycle, and in the cycle after a stall the core is served first. The agent can reach only the main RAM and the scratch RAM.

Top module: `mem_strobe_router`

## Requirements
- R1: A CPU data access with address 0x0000–0x1FFF asserts `cs_main` only, and `int_addr` equals the CPU address.
- R2: A CPU data access with address 0xE000–0xE1FF asserts `cs_scr` only. One with address 0xE200–0xFFFF asserts `cs_csr` only.
- R3: With `code_ext`=0, a fetch (`cpu_psen_n`=0) in 0x0000–0x1FFF drives `int_rd_n` low and `cs_main` high, and keeps `ext_psen_n` high.
- R4: With `code_ext`=1, a fetch in 0x0000–0x1FFF drives `ext_psen_n` low and asserts no chip select.
- R5: A fetch at 0x2000 or above drives `ext_psen_n` low and asserts no chip select, in both modes.
- R6: `ext_rd_n` and `ext_wr_n` follow `cpu_rd_n` and `cpu_wr_n` only for addresses 0x2000–0xDFFF. For every on-chip address they stay high.
- R7: At most one chip select is high in any cycle. None is high for an access routed to the pins, or when the bus is idle.
- R8: A request on the agent port (`dma_req`=1) is granted only for addresses in the main RAM or scratch RAM. A request to any other address gets `dma_gnt`=0 and drives no chip select. A granted access uses `dma_we` (1 = write, 0 = read) to pick `int_wr_n` or `int_rd_n`.
- R9: A granted agent access owns the internal port. If the CPU targets any on-chip region in the same cycle, `cpu_stall` is high and the agent's address and chip select are driven.
- R10: In the cycle after `cpu_stall` is high, the agent is not granted and the CPU access is served, so `cpu_stall` never stays high for two cycles in a row.
- R11: During reset with an idle bus, all chip selects are low and all strobes are high. After reset, the first conflict is won by the agent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| code_ext | input | 1 | 1 = code held externally, 0 = low 8 KB holds code |
| cpu_addr | input | 16 | CPU bus address |
| cpu_psen_n | input | 1 | CPU program-fetch strobe, active low |
| cpu_rd_n | input | 1 | CPU data-read strobe, active low |
| cpu_wr_n | input | 1 | CPU data-write strobe, active low |
| dma_req | input | 1 | Bulk-transfer agent request |
| dma_we | input | 1 | Agent direction, 1 = write |
| dma_addr | input | 16 | Agent address |
| dma_gnt | output | 1 | Agent owns the internal port this cycle |
| cpu_stall | output | 1 | CPU on-chip access held off this cycle |
| int_addr | output | 16 | Internal memory address |
| cs_main | output | 1 | Main RAM select |
| cs_scr | output | 1 | Scratch RAM select |
| cs_csr | output | 1 | Register/buffer window select |
| int_rd_n | output | 1 | Internal read strobe, active low |
| int_wr_n | output | 1 | Internal write strobe, active low |
| ext_psen_n | output | 1 | External program-fetch strobe, active low |
| ext_rd_n | output | 1 | External data-read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The bound checker checks several properties on every cycle. It checks that the chip selects are one-hot or idle, and that external data strobes appear only for the off-chip window. It checks that in internal-code mode no external fetch strobe appears below 0x2000. It also checks that grants stay inside the two agent-visible RAMs and that a stall is never held for two cycles. Three behaviours are shown only by the bench's scenarios against its reference function: the exact address and strobe chosen by the internal mux, the alternation of priority across repeated conflicts, and the behaviour at each region boundary in both code modes.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum logic [1:0] {
      RGN_MAIN = 2'd0,
      RGN_SCR  = 2'd1,
      RGN_CSR  = 2'd2,
      RGN_EXT  = 2'd3
   } region_e;
endpackage

// File: rtl/msr_region_decode.sv
module msr_region_decode
   import msr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned MAIN_BYTES = 8192,
   parameter int unsigned SCR_BASE   = 32'hE000,
   parameter int unsigned SCR_BYTES  = 512
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam logic [ADDR_W-1:0] MAIN_TOP = ADDR_W'(MAIN_BYTES - 1);
   localparam logic [ADDR_W-1:0] SCR_LO   = ADDR_W'(SCR_BASE);
   localparam logic [ADDR_W-1:0] SCR_TOP  = ADDR_W'(SCR_BASE + SCR_BYTES - 1);

   // Everything above the scratch RAM up to the top of the map is the
   // register/buffer window; the gap between main RAM and scratch is off chip.
   always_comb begin
      if (addr <= MAIN_TOP)                       region = RGN_MAIN;
      else if (addr >= SCR_LO && addr <= SCR_TOP) region = RGN_SCR;
      else if (addr > SCR_TOP)                    region = RGN_CSR;
      else                                        region = RGN_EXT;
   end
endmodule

// File: rtl/msr_ext_gate.sv
module msr_ext_gate
   import msr_pkg::*;
(
   input  logic    code_ext,
   input  region_e cpu_region,
   input  logic    psen_n,
   input  logic    rd_n,
   input  logic    wr_n,
   output logic    fetch_on_chip,
   output logic    data_on_chip,
   output logic    ext_psen_n,
   output logic    ext_rd_n,
   output logic    ext_wr_n
);
   // Only the low RAM can hold code, and only in internal-code mode.
   assign fetch_on_chip = ~code_ext & (cpu_region == RGN_MAIN);
   assign data_on_chip  = (cpu_region != RGN_EXT);

   assign ext_psen_n = psen_n | fetch_on_chip;
   assign ext_rd_n   = rd_n   | data_on_chip;
   assign ext_wr_n   = wr_n   | data_on_chip;
endmodule

// File: rtl/msr_port_arbiter.sv
module msr_port_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_int,
   input  logic dma_ok,
   output logic dma_gnt,
   output logic cpu_stall
);
   logic cpu_prio_q;

   assign dma_gnt   = dma_ok & ~cpu_prio_q;
   assign cpu_stall = dma_gnt & cpu_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_prio_q <= 1'b0;
      else        cpu_prio_q <= cpu_stall;
   end
endmodule

// File: rtl/mem_strobe_router.sv
module mem_strobe_router
   import msr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned MAIN_BYTES = 8192,
   parameter int unsigned SCR_BASE   = 32'hE000,
   parameter int unsigned SCR_BYTES  = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              code_ext,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_psen_n,
   input  logic              cpu_rd_n,
   input  logic              cpu_wr_n,
   input  logic              dma_req,
   input  logic              dma_we,
   input  logic [ADDR_W-1:0] dma_addr,
   output logic              dma_gnt,
   output logic              cpu_stall,
   output logic [ADDR_W-1:0] int_addr,
   output logic              cs_main,
   output logic              cs_scr,
   output logic              cs_csr,
   output logic              int_rd_n,
   output logic              int_wr_n,
   output logic              ext_psen_n,
   output logic              ext_rd_n,
   output logic              ext_wr_n
);
   localparam int unsigned N_REQ = 2;   // 0: CPU, 1: transfer agent

   if (MAIN_BYTES == 0 || SCR_BYTES == 0)
      $error("region sizes must be non-zero");
   if (SCR_BASE < MAIN_BYTES)
      $error("scratch RAM must sit above main RAM");
   if (SCR_BASE + SCR_BYTES > (64'd1 << ADDR_W))
      $error("scratch RAM exceeds address space");

   logic [ADDR_W-1:0] req_addr [N_REQ];
   region_e           req_rgn  [N_REQ];

   assign req_addr[0] = cpu_addr;
   assign req_addr[1] = dma_addr;

   for (genvar g = 0; g < N_REQ; g++) begin : g_dec
      msr_region_decode #(
         .ADDR_W    (ADDR_W),
         .MAIN_BYTES(MAIN_BYTES),
         .SCR_BASE  (SCR_BASE),
         .SCR_BYTES (SCR_BYTES)
      ) u_dec (
         .addr  (req_addr[g]),
         .region(req_rgn[g])
      );
   end

   logic fetch_on_chip, data_on_chip;

   msr_ext_gate u_gate (
      .code_ext     (code_ext),
      .cpu_region   (req_rgn[0]),
      .psen_n       (cpu_psen_n),
      .rd_n         (cpu_rd_n),
      .wr_n         (cpu_wr_n),
      .fetch_on_chip(fetch_on_chip),
      .data_on_chip (data_on_chip),
      .ext_psen_n   (ext_psen_n),
      .ext_rd_n     (ext_rd_n),
      .ext_wr_n     (ext_wr_n)
   );

   logic cpu_fetch_int, cpu_rd_int, cpu_wr_int, cpu_int, dma_ok;

   assign cpu_fetch_int = ~cpu_psen_n & fetch_on_chip;
   assign cpu_rd_int    = ~cpu_rd_n   & data_on_chip;
   assign cpu_wr_int    = ~cpu_wr_n   & data_on_chip;
   assign cpu_int       = cpu_fetch_int | cpu_rd_int | cpu_wr_int;
   assign dma_ok        = dma_req & ((req_rgn[1] == RGN_MAIN) | (req_rgn[1] == RGN_SCR));

   msr_port_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_int  (cpu_int),
      .dma_ok   (dma_ok),
      .dma_gnt  (dma_gnt),
      .cpu_stall(cpu_stall)
   );

   region_e sel_rgn;
   logic    sel_valid;

   always_comb begin
      sel_valid = 1'b0;
      sel_rgn   = RGN_EXT;
      int_addr  = cpu_addr;
      int_rd_n  = 1'b1;
      int_wr_n  = 1'b1;
      if (dma_gnt) begin
         sel_valid = 1'b1;
         sel_rgn   = req_rgn[1];
         int_addr  = dma_addr;
         int_rd_n  = dma_we;
         int_wr_n  = ~dma_we;
      end else if (cpu_int) begin
         sel_valid = 1'b1;
         sel_rgn   = req_rgn[0];
         // fetch and read merge onto one internal read strobe
         int_rd_n  = ~(cpu_fetch_int | cpu_rd_int);
         int_wr_n  = ~cpu_wr_int;
      end
   end

   assign cs_main = sel_valid & (sel_rgn == RGN_MAIN);
   assign cs_scr  = sel_valid & (sel_rgn == RGN_SCR);
   assign cs_csr  = sel_valid & (sel_rgn == RGN_CSR);
endmodule

// File: rtl/mem_strobe_router_chk.sv
module mem_strobe_router_chk #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned MAIN_BYTES = 8192,
   parameter int unsigned SCR_BASE   = 32'hE000,
   parameter int unsigned SCR_BYTES  = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              code_ext,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_psen_n,
   input logic [ADDR_W-1:0] dma_addr,
   input logic              dma_gnt,
   input logic              cpu_stall,
   input logic              cs_main,
   input logic              cs_scr,
   input logic              cs_csr,
   input logic              ext_psen_n,
   input logic              ext_rd_n,
   input logic              ext_wr_n
);
   localparam logic [ADDR_W-1:0] MAIN_END = ADDR_W'(MAIN_BYTES);
   localparam logic [ADDR_W-1:0] SCR_LO   = ADDR_W'(SCR_BASE);
   localparam logic [ADDR_W-1:0] SCR_END  = ADDR_W'(SCR_BASE + SCR_BYTES);

   p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_main, cs_scr, cs_csr}));

   p_ext_rd_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n |-> (cpu_addr >= MAIN_END && cpu_addr < SCR_LO));

   p_ext_wr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_wr_n |-> (cpu_addr >= MAIN_END && cpu_addr < SCR_LO));

   p_no_ext_fetch_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_psen_n && !code_ext) |-> cpu_addr >= MAIN_END);

   p_ext_fetch_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_ext && !cpu_psen_n) |-> !ext_psen_n);

   p_dma_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_gnt |-> (dma_addr < MAIN_END || (dma_addr >= SCR_LO && dma_addr < SCR_END)));

   p_stall_has_gnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |-> dma_gnt);

   p_stall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall |=> !cpu_stall);
endmodule

bind mem_strobe_router mem_strobe_router_chk #(
   .ADDR_W    (ADDR_W),
   .MAIN_BYTES(MAIN_BYTES),
   .SCR_BASE  (SCR_BASE),
   .SCR_BYTES (SCR_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .code_ext  (code_ext),
   .cpu_addr  (cpu_addr),
   .cpu_psen_n(cpu_psen_n),
   .dma_addr  (dma_addr),
   .dma_gnt   (dma_gnt),
   .cpu_stall (cpu_stall),
   .cs_main   (cs_main),
   .cs_scr    (cs_scr),
   .cs_csr    (cs_csr),
   .ext_psen_n(ext_psen_n),
   .ext_rd_n  (ext_rd_n),
   .ext_wr_n  (ext_wr_n)
);

// File: tb/tb_mem_strobe_router.sv
module tb_mem_strobe_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        code_ext = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_psen_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
   logic        dma_req = 1'b0, dma_we = 1'b0;
   logic [15:0] dma_addr = '0;
   logic        dma_gnt, cpu_stall, cs_main, cs_scr, cs_csr;
   logic        int_rd_n, int_wr_n, ext_psen_n, ext_rd_n, ext_wr_n;
   logic [15:0] int_addr;

   int checks = 0, errors = 0;
   logic prio = 1'b0, last_stall = 1'b0;

   always #2 clk = ~clk;

   mem_strobe_router dut (
      .clk(clk), .rst_n(rst_n), .code_ext(code_ext), .cpu_addr(cpu_addr),
      .cpu_psen_n(cpu_psen_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
      .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
      .dma_gnt(dma_gnt), .cpu_stall(cpu_stall), .int_addr(int_addr),
      .cs_main(cs_main), .cs_scr(cs_scr), .cs_csr(cs_csr),
      .int_rd_n(int_rd_n), .int_wr_n(int_wr_n),
      .ext_psen_n(ext_psen_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n));

   // 0 main, 1 scratch, 2 register window, 3 off chip
   function automatic int rgn(logic [15:0] a);
      if (a < 16'h2000) return 0;
      if (a >= 16'hE000 && a < 16'hE200) return 1;
      if (a >= 16'hE200) return 2;
      return 3;
   endfunction

   function automatic logic [2:0] cs_of(int r);
      return (r == 0) ? 3'b100 : (r == 1) ? 3'b010 : (r == 2) ? 3'b001 : 3'b000;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare every output with the value the requirements give
   task automatic check_all(string ctx);
      logic fetch, fon, don, cint, dok, gnt, stall, rdn, wrn;
      logic [2:0] cs;
      logic [15:0] a;
      int cr, dr;
      fetch = !cpu_psen_n;
      cr    = rgn(cpu_addr);
      dr    = rgn(dma_addr);
      fon   = !code_ext && cr == 0;               // R3, R4, R5
      don   = cr != 3;                            // R6
      cint  = (fetch && fon) || ((!cpu_rd_n || !cpu_wr_n) && don);
      dok   = dma_req && (dr == 0 || dr == 1);    // R8
      gnt   = dok && !prio;                       // R10
      stall = gnt && cint;                        // R9
      cs = 3'b000; rdn = 1'b1; wrn = 1'b1; a = int_addr;
      if (gnt) begin
         cs = cs_of(dr); rdn = dma_we; wrn = !dma_we; a = dma_addr;
      end else if (cint) begin
         cs = cs_of(cr); a = cpu_addr;
         rdn = !((fetch && fon) || (!cpu_rd_n && don));
         wrn = cpu_wr_n;
      end
      chk({ctx, " R7 cs"}, {29'd0, cs_main, cs_scr, cs_csr}, {29'd0, cs});
      chk({ctx, " R1 int_addr"}, {16'd0, int_addr}, {16'd0, a});
      chk({ctx, " R3 int_strb"}, {30'd0, int_rd_n, int_wr_n}, {30'd0, rdn, wrn});
      chk({ctx, " R6 ext_strb"}, {29'd0, ext_psen_n, ext_rd_n, ext_wr_n},
          {29'd0, cpu_psen_n | fon, cpu_rd_n | don, cpu_wr_n | don});
      chk({ctx, " R8 dma_gnt"}, {31'd0, dma_gnt}, {31'd0, gnt});
      chk({ctx, " R9 stall"}, {31'd0, cpu_stall}, {31'd0, stall});
      last_stall = stall;
   endtask

   // one cycle: drive after the edge, sample before the next one
   task automatic step(string ctx, logic mode, logic [15:0] ca, int kind,
                       logic dr, logic dw, logic [15:0] da);
      @(posedge clk);
      prio = last_stall;
      #1;
      code_ext = mode; cpu_addr = ca;
      cpu_psen_n = (kind != 1); cpu_rd_n = (kind != 2); cpu_wr_n = (kind != 3);
      dma_req = dr; dma_we = dw; dma_addr = da;
      #2;
      check_all(ctx);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] edges [8];
      int seed;
      edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'hDFFF,
                16'hE000, 16'hE1FF, 16'hE200, 16'hFFFF};
      seed = $urandom(32'h5EED);
      // R11: reset with idle bus
      #3;
      chk("R11 reset cs", {29'd0, cs_main, cs_scr, cs_csr}, 32'd0);
      chk("R11 reset strobes", {27'd0, int_rd_n, int_wr_n, ext_psen_n, ext_rd_n, ext_wr_n}, 32'h1F);
      @(posedge clk); #1 rst_n = 1'b1;

      // R11: first conflict after reset goes to the agent
      step("R11 first", 1'b0, 16'h0010, 2, 1'b1, 1'b1, 16'h0100);
      chk("R11 first stall", {31'd0, cpu_stall}, 32'd1);
      // R10: next cycle the CPU is served
      step("R10 cpu turn", 1'b0, 16'h0010, 2, 1'b1, 1'b1, 16'h0100);
      chk("R10 no gnt", {31'd0, dma_gnt}, 32'd0);
      chk("R10 cpu addr", {16'd0, int_addr}, 32'h0010);
      step("R10 again", 1'b0, 16'h0010, 2, 1'b1, 1'b1, 16'h0100);
      chk("R10 gnt back", {31'd0, dma_gnt}, 32'd1);

      // R3/R4/R5: fetch routing at every boundary in both modes
      for (int m = 0; m < 2; m++)
         for (int i = 0; i < 8; i++) begin
            step("R5 fetch edge", m[0], edges[i], 1, 1'b0, 1'b0, 16'h0);
            if (i < 2 && m == 0)
               chk("R3 fetch internal", {30'd0, ext_psen_n, cs_main}, 32'd3);
            else
               chk("R4 fetch external", {30'd0, ext_psen_n, cs_main}, 32'd0);
         end
      // R1/R2/R6: data read and write at every boundary
      for (int k = 2; k < 4; k++)
         for (int i = 0; i < 8; i++)
            step("R2 data edge", 1'b1, edges[i], k, 1'b0, 1'b0, 16'h0);
      // R8: agent to off-chip and register addresses is not granted
      step("R8 reject", 1'b0, 16'h4000, 0, 1'b1, 1'b1, 16'h3000);
      chk("R8 no gnt ext", {28'd0, dma_gnt, cs_main, cs_scr, cs_csr}, 32'd0);
      step("R8 reject csr", 1'b0, 16'h4000, 0, 1'b1, 1'b0, 16'hE300);
      chk("R8 no gnt csr", {28'd0, dma_gnt, cs_main, cs_scr, cs_csr}, 32'd0);
      step("R8 scratch", 1'b0, 16'h4000, 0, 1'b1, 1'b0, 16'hE1FF);
      chk("R8 scratch gnt", {30'd0, dma_gnt, cs_scr}, 32'd3);

      // random mix, addresses biased to boundaries
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] ca, da;
         ca = ($urandom % 2) ? edges[$urandom % 8] + 16'($urandom % 3) - 16'd1 : 16'($urandom);
         da = ($urandom % 2) ? edges[$urandom % 8] : 16'($urandom);
         step("R9 random", 1'($urandom), ca, int'($urandom % 4),
              1'($urandom), 1'($urandom), da);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule